// File: doc/BRIEF.md
# Execution Context Migration Port

This block sits between a core's thread-context storage and the migration channel of the on-chip network. When a thread leaves the core, the core pulses a start strobe. The block then captures the whole architectural context (register state and translation entries) from a wide read port. It sends the context out as one header flit followed by a fixed number of payload flits, one flit per accepted cycle. When a thread arrives, the block collects a header flit and the payload flits from the router. It presents the complete context to the core's slot with a one-cycle write strobe, waits out the pipeline insertion delay, and then pulses a ready signal so the slot can resume execution.

With the default parameters the context is 1536 bits and the flit is 256 bits. That gives 6 payload flits, so each packet is 7 flits. A 4096-bit context with 256-bit or 512-bit flits gives 16 or 8 payload flits by changing parameters only. The payload flit count is the ceiling of context width over flit width, and any unused bits of the last flit are zero.

The send side has three states. `TX_IDLE` moves to `TX_HEAD` on start. `TX_HEAD` moves to `TX_BODY` when the header is accepted. `TX_BODY` returns to `TX_IDLE` when the last payload flit is accepted. The receive side has five states. `RX_HEAD` moves to `RX_BODY` when a header is accepted. `RX_BODY` moves to `RX_WRITE` when the last payload flit is accepted. `RX_WRITE` always moves to `RX_INSERT`. `RX_INSERT` moves to `RX_READY` after the insertion cycles have elapsed. `RX_READY` always returns to `RX_HEAD`.

Top module: `ctx_migrate_port`

## Requirements
- R1: While `rst_n` is low, `tx_valid`, `tx_last`, `ul_busy`, `ul_done`, `ctx_wr_en` and `ld_ready` are 0 and `rx_ready` is 1.
- R2: A start accepted in idle produces exactly 1 + ceil(CTX_W/FLIT_W) flits. Payload flit k carries context bits [k*FLIT_W +: FLIT_W], sent from k = 0 upward. `tx_last` is high only on the final payload flit.
- R3: The header flit has these fields: bit 0 is the eviction flag, bits [8:1] the destination core, bits [16:9] the sending core (`my_core`), bits [24:17] the thread's native core and bits [28:25] the thread ID. All other bits are 0.
- R4: While `tx_valid` is high and `tx_ready` is low, the next cycle keeps `tx_valid` high with `tx_flit` and `tx_last` unchanged. No flit is skipped or repeated.
- R5: `ul_done` is a one-cycle pulse in the cycle after the final flit's handshake. `ul_busy` is low in that same cycle.
- R6: The context is captured in the cycle of the accepted start. A start while `ul_busy` is high is ignored, and later changes of `ctx_rd_data` do not alter the packet.
- R7: In the cycle after the last payload flit of an incoming packet is accepted, `ctx_wr_en` is high for one cycle. In that cycle `ctx_wr_data` holds the reassembled context, `ld_src`, `ld_thread` and `ld_evict` hold the header fields, and `ld_native` is 1 exactly when the header's native core equals `my_core`.
- R8: `rx_ready` is low from the `ctx_wr_en` cycle through the `ld_ready` cycle, so no flit is taken while a context is written or inserted.
- R9: `ld_ready` is a one-cycle pulse exactly INS_CYC+1 cycles after `ctx_wr_en` (4 cycles with the default INS_CYC of 3).
- R10: Gaps in `rx_valid` inside a packet only delay reassembly and do not change the written context.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_core | input | CORE_W | Index of this core |
| ul_start | input | 1 | Start strobe for sending a context |
| ul_dst | input | CORE_W | Destination core of the outgoing thread |
| ul_native | input | CORE_W | Native core of the outgoing thread |
| ul_thread | input | TID_W | Outgoing thread ID |
| ul_evict | input | 1 | Outgoing move is an eviction |
| ctx_rd_data | input | CTX_W | Wide context read port |
| ul_busy | output | 1 | Send in progress |
| ul_done | output | 1 | Send complete pulse |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Network accepts outgoing flit |
| tx_flit | output | FLIT_W | Outgoing flit |
| tx_last | output | 1 | Outgoing flit is the last of its packet |
| rx_valid | input | 1 | Incoming flit valid |
| rx_ready | output | 1 | Block accepts incoming flit |
| rx_flit | input | FLIT_W | Incoming flit |
| ctx_wr_en | output | 1 | Context slot write strobe |
| ctx_wr_data | output | CTX_W | Reassembled context |
| ld_native | output | 1 | Incoming thread is native here (native slot) |
| ld_src | output | CORE_W | Core the thread came from |
| ld_thread | output | TID_W | Incoming thread ID |
| ld_evict | output | 1 | Incoming move is an eviction |
| ld_ready | output | 1 | Slot ready for execution pulse |

## Verification
The assertions check four properties on every cycle: a stalled outgoing flit stays stable, every completion follows a final-flit handshake after exactly the packet's flit count, the receive side refuses flits from write through ready, and the ready pulse lies exactly the insertion delay after the write. Several properties can only be shown by the bench scenarios. These are the bit layout of the header, the ordering of payload chunks, the capture of the context at start, the ignoring of a second start, and correct reassembly across gaps in the incoming stream.

// File: rtl/ctxm_pkg.sv
package ctxm_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HEAD,
        TX_BODY
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_HEAD,
        RX_BODY,
        RX_WRITE,
        RX_INSERT,
        RX_READY
    } rx_state_e;

endpackage

// File: rtl/ctxm_tx.sv
module ctxm_tx
    import ctxm_pkg::*;
#(
    parameter int CTX_W  = 1536,
    parameter int FLIT_W = 256,
    parameter int CORE_W = 8,
    parameter int TID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] my_core,
    input  logic              ul_start,
    input  logic [CORE_W-1:0] ul_dst,
    input  logic [CORE_W-1:0] ul_native,
    input  logic [TID_W-1:0]  ul_thread,
    input  logic              ul_evict,
    input  logic [CTX_W-1:0]  ctx_rd_data,
    output logic              ul_busy,
    output logic              ul_done,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [FLIT_W-1:0] tx_flit,
    output logic              tx_last
);

    localparam int NFL   = (CTX_W + FLIT_W - 1) / FLIT_W;
    localparam int PAD_W = NFL * FLIT_W;
    localparam int CNT_W = $clog2(NFL + 1);
    localparam int HDR_W = 1 + 3 * CORE_W + TID_W;

    tx_state_e         state, nxt;
    logic [PAD_W-1:0]  shreg;
    logic [PAD_W-1:0]  snap;
    logic [HDR_W-1:0]  hdr;
    logic [CNT_W-1:0]  cnt;
    logic              done_q;
    logic              at_last;

    generate
        if (PAD_W > CTX_W) begin : g_pad
            assign snap = {{(PAD_W - CTX_W){1'b0}}, ctx_rd_data};
        end else begin : g_nopad
            assign snap = ctx_rd_data;
        end
    endgenerate

    assign at_last = (cnt == CNT_W'(NFL - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (ul_start)            nxt = TX_HEAD;
            TX_HEAD: if (tx_ready)            nxt = TX_BODY;
            TX_BODY: if (tx_ready && at_last) nxt = TX_IDLE;
            default:                          nxt = TX_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_flit  = shreg[FLIT_W-1:0];
        unique case (state)
            TX_IDLE: ;
            TX_HEAD: begin
                tx_valid = 1'b1;
                tx_flit  = {{(FLIT_W - HDR_W){1'b0}}, hdr};
            end
            TX_BODY: begin
                tx_valid = 1'b1;
                tx_last  = at_last;
            end
            default: ;
        endcase
        ul_busy = (state != TX_IDLE);
        ul_done = done_q;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            hdr    <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                TX_IDLE: if (ul_start) begin
                    shreg <= snap;
                    hdr   <= {ul_thread, ul_native, my_core, ul_dst, ul_evict};
                    cnt   <= '0;
                end
                TX_HEAD: ;
                TX_BODY: if (tx_ready) begin
                    shreg  <= shreg >> FLIT_W;
                    cnt    <= cnt + 1'b1;
                    done_q <= at_last;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctxm_rx.sv
module ctxm_rx
    import ctxm_pkg::*;
#(
    parameter int CTX_W   = 1536,
    parameter int FLIT_W  = 256,
    parameter int CORE_W  = 8,
    parameter int TID_W   = 4,
    parameter int INS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] my_core,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              ctx_wr_en,
    output logic [CTX_W-1:0]  ctx_wr_data,
    output logic              ld_native,
    output logic [CORE_W-1:0] ld_src,
    output logic [TID_W-1:0]  ld_thread,
    output logic              ld_evict,
    output logic              ld_ready
);

    localparam int NFL    = (CTX_W + FLIT_W - 1) / FLIT_W;
    localparam int PAD_W  = NFL * FLIT_W;
    localparam int CNT_W  = $clog2(NFL + 1);
    localparam int INS_W  = $clog2(INS_CYC + 1);
    localparam int SRC_LO = 1 + CORE_W;
    localparam int NAT_LO = 1 + 2 * CORE_W;
    localparam int TID_LO = 1 + 3 * CORE_W;

    rx_state_e         state, nxt;
    logic [PAD_W-1:0]  asm_q;
    logic [PAD_W-1:0]  asm_nx;
    logic [CNT_W-1:0]  cnt;
    logic [INS_W-1:0]  ins;
    logic [CORE_W-1:0] src_q, nat_q;
    logic [TID_W-1:0]  tid_q;
    logic              ev_q;
    logic              body_last;
    logic              ins_last;

    generate
        if (NFL == 1) begin : g_one
            assign asm_nx = rx_flit;
        end else begin : g_many
            assign asm_nx = {rx_flit, asm_q[PAD_W-1:FLIT_W]};
        end
    endgenerate

    assign body_last = (cnt == CNT_W'(NFL - 1));
    assign ins_last  = (ins == INS_W'(INS_CYC - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_HEAD;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            RX_HEAD:   if (rx_valid)              nxt = RX_BODY;
            RX_BODY:   if (rx_valid && body_last) nxt = RX_WRITE;
            RX_WRITE:                             nxt = RX_INSERT;
            RX_INSERT: if (ins_last)              nxt = RX_READY;
            RX_READY:                             nxt = RX_HEAD;
            default:                              nxt = RX_HEAD;
        endcase
    end

    // Outputs
    always_comb begin
        rx_ready  = 1'b0;
        ctx_wr_en = 1'b0;
        ld_ready  = 1'b0;
        unique case (state)
            RX_HEAD:   rx_ready  = 1'b1;
            RX_BODY:   rx_ready  = 1'b1;
            RX_WRITE:  ctx_wr_en = 1'b1;
            RX_INSERT: ;
            RX_READY:  ld_ready  = 1'b1;
            default: ;
        endcase
        ctx_wr_data = asm_q[CTX_W-1:0];
        ld_src      = src_q;
        ld_thread   = tid_q;
        ld_evict    = ev_q;
        ld_native   = (nat_q == my_core);
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q <= '0;
            cnt   <= '0;
            ins   <= '0;
            src_q <= '0;
            nat_q <= '0;
            tid_q <= '0;
            ev_q  <= 1'b0;
        end else begin
            unique case (state)
                RX_HEAD: if (rx_valid) begin
                    ev_q  <= rx_flit[0];
                    src_q <= rx_flit[SRC_LO +: CORE_W];
                    nat_q <= rx_flit[NAT_LO +: CORE_W];
                    tid_q <= rx_flit[TID_LO +: TID_W];
                    cnt   <= '0;
                end
                RX_BODY: if (rx_valid) begin
                    asm_q <= asm_nx;
                    cnt   <= cnt + 1'b1;
                end
                RX_WRITE:  ins <= '0;
                RX_INSERT: ins <= ins + 1'b1;
                RX_READY:  ;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/ctx_migrate_port.sv
module ctx_migrate_port #(
    parameter int CTX_W   = 1536,
    parameter int FLIT_W  = 256,
    parameter int CORE_W  = 8,
    parameter int TID_W   = 4,
    parameter int INS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] my_core,
    input  logic              ul_start,
    input  logic [CORE_W-1:0] ul_dst,
    input  logic [CORE_W-1:0] ul_native,
    input  logic [TID_W-1:0]  ul_thread,
    input  logic              ul_evict,
    input  logic [CTX_W-1:0]  ctx_rd_data,
    output logic              ul_busy,
    output logic              ul_done,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [FLIT_W-1:0] tx_flit,
    output logic              tx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [FLIT_W-1:0] rx_flit,
    output logic              ctx_wr_en,
    output logic [CTX_W-1:0]  ctx_wr_data,
    output logic              ld_native,
    output logic [CORE_W-1:0] ld_src,
    output logic [TID_W-1:0]  ld_thread,
    output logic              ld_evict,
    output logic              ld_ready
);

    ctxm_tx #(
        .CTX_W(CTX_W), .FLIT_W(FLIT_W), .CORE_W(CORE_W), .TID_W(TID_W)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .my_core(my_core),
        .ul_start(ul_start), .ul_dst(ul_dst), .ul_native(ul_native),
        .ul_thread(ul_thread), .ul_evict(ul_evict), .ctx_rd_data(ctx_rd_data),
        .ul_busy(ul_busy), .ul_done(ul_done),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_last(tx_last)
    );

    ctxm_rx #(
        .CTX_W(CTX_W), .FLIT_W(FLIT_W), .CORE_W(CORE_W), .TID_W(TID_W), .INS_CYC(INS_CYC)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .my_core(my_core),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_flit(rx_flit),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data),
        .ld_native(ld_native), .ld_src(ld_src), .ld_thread(ld_thread),
        .ld_evict(ld_evict), .ld_ready(ld_ready)
    );

endmodule

// File: rtl/ctxm_chk.sv
module ctxm_chk #(
    parameter int CTX_W   = 1536,
    parameter int FLIT_W  = 256,
    parameter int INS_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ul_busy,
    input logic              ul_done,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [FLIT_W-1:0] tx_flit,
    input logic              tx_last,
    input logic              rx_ready,
    input logic              ctx_wr_en,
    input logic              ld_ready
);

    localparam int NFL = (CTX_W + FLIT_W - 1) / FLIT_W;

    logic [15:0] beats;
    logic [15:0] since_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats <= '0;
        end else if (ul_done) begin
            beats <= '0;
        end else if (tx_valid && tx_ready) begin
            beats <= beats + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_wr <= '0;
        end else if (ctx_wr_en) begin
            since_wr <= 16'd1;
        end else if (since_wr != 16'd0 && since_wr != 16'hFFFF) begin
            since_wr <= since_wr + 1'b1;
        end
    end

    assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ul_done |-> (beats == 16'(NFL + 1)));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit) && $stable(tx_last)));

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ul_done |-> $past(tx_valid && tx_ready && tx_last));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ul_done |-> !ul_busy);

    assert_write_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_wr_en || ld_ready) |-> !rx_ready);

    assert_ready_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> (since_wr == 16'(INS_CYC + 1)));

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |=> !ld_ready);

endmodule

bind ctx_migrate_port ctxm_chk #(
    .CTX_W(CTX_W), .FLIT_W(FLIT_W), .INS_CYC(INS_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ul_busy(ul_busy), .ul_done(ul_done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_last(tx_last),
    .rx_ready(rx_ready), .ctx_wr_en(ctx_wr_en), .ld_ready(ld_ready)
);

// File: tb/ctx_migrate_port_test.sv
`timescale 1ns/1ps
module ctx_migrate_port_test;

    localparam int CTX_W   = 1536;
    localparam int FLIT_W  = 256;
    localparam int CORE_W  = 8;
    localparam int TID_W   = 4;
    localparam int INS_CYC = 3;
    localparam int NFL     = (CTX_W + FLIT_W - 1) / FLIT_W;
    localparam int R_RDY   = INS_CYC + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CORE_W-1:0] my_core = 8'h2A;
    logic              ul_start = 1'b0;
    logic [CORE_W-1:0] ul_dst = '0, ul_native = '0;
    logic [TID_W-1:0]  ul_thread = '0;
    logic              ul_evict = 1'b0;
    logic [CTX_W-1:0]  ctx_rd_data = '0;
    logic              ul_busy, ul_done, tx_valid, tx_last;
    logic              tx_ready = 1'b0;
    logic [FLIT_W-1:0] tx_flit;
    logic              rx_valid = 1'b0;
    logic              rx_ready;
    logic [FLIT_W-1:0] rx_flit = '0;
    logic              ctx_wr_en, ld_native, ld_evict, ld_ready;
    logic [CTX_W-1:0]  ctx_wr_data;
    logic [CORE_W-1:0] ld_src;
    logic [TID_W-1:0]  ld_thread;

    always #4 clk = ~clk;

    ctx_migrate_port uut (
        .clk(clk), .rst_n(rst_n), .my_core(my_core),
        .ul_start(ul_start), .ul_dst(ul_dst), .ul_native(ul_native),
        .ul_thread(ul_thread), .ul_evict(ul_evict), .ctx_rd_data(ctx_rd_data),
        .ul_busy(ul_busy), .ul_done(ul_done),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_flit(rx_flit),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data), .ld_native(ld_native),
        .ld_src(ld_src), .ld_thread(ld_thread), .ld_evict(ld_evict), .ld_ready(ld_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    int ncyc = 0;

    // Reference model state
    logic [FLIT_W-1:0] m_q[$];
    bit                m_busy = 0;
    bit                m_done = 0;
    int                r_st = 0;
    int                r_cnt = 0;
    logic [CTX_W-1:0]  r_ctx;
    logic [CORE_W-1:0] r_src, r_nat;
    logic [TID_W-1:0]  r_tid;
    bit                r_ev;

    task automatic chk(input bit ok, input string tag, input logic [CTX_W-1:0] act,
                       input logic [CTX_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, ncyc, act, exp);
        end
    endtask

    function automatic logic [FLIT_W-1:0] mk_hdr(input logic [CORE_W-1:0] dst,
        input logic [CORE_W-1:0] src, input logic [CORE_W-1:0] nat,
        input logic [TID_W-1:0] tid, input bit ev);
        logic [FLIT_W-1:0] h;
        h = '0;
        h[0]     = ev;
        h[8:1]   = dst;
        h[16:9]  = src;
        h[24:17] = nat;
        h[28:25] = tid;
        return h;
    endfunction

    function automatic logic [CTX_W-1:0] rnd_ctx();
        logic [CTX_W-1:0] v;
        for (int i = 0; i < CTX_W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Advance the model by the effect of the coming clock edge.
    task automatic model_edge();
        bit was_busy;
        was_busy = m_busy;
        m_done = 0;
        if (was_busy && tx_ready) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0) begin
                m_busy = 0;
                m_done = 1;
            end
        end
        if (!was_busy && ul_start) begin
            m_q.push_back(mk_hdr(ul_dst, my_core, ul_native, ul_thread, ul_evict));
            for (int k = 0; k < NFL; k++) m_q.push_back(ctx_rd_data[k*FLIT_W +: FLIT_W]);
            m_busy = 1;
        end
        if (r_st == 0) begin
            if (rx_valid) begin
                r_cnt++;
                if (r_cnt == NFL + 1) r_st = 1;
            end
        end else if (r_st == R_RDY) begin
            r_st = 0;
            r_cnt = 0;
        end else begin
            r_st++;
        end
    endtask

    task automatic compare();
        chk(tx_valid == m_busy, "R2 tx_valid", CTX_W'(tx_valid), CTX_W'(m_busy));
        chk(ul_busy == m_busy, "R6 ul_busy", CTX_W'(ul_busy), CTX_W'(m_busy));
        chk(ul_done == m_done, "R5 ul_done", CTX_W'(ul_done), CTX_W'(m_done));
        if (m_busy) begin
            chk(tx_flit == m_q[0], "R2 R3 tx_flit", CTX_W'(tx_flit), CTX_W'(m_q[0]));
            chk(tx_last == (m_q.size() == 1), "R2 tx_last", CTX_W'(tx_last),
                CTX_W'(m_q.size() == 1));
        end
        chk(rx_ready == (r_st == 0), "R8 rx_ready", CTX_W'(rx_ready), CTX_W'(r_st == 0));
        chk(ctx_wr_en == (r_st == 1), "R7 ctx_wr_en", CTX_W'(ctx_wr_en), CTX_W'(r_st == 1));
        chk(ld_ready == (r_st == R_RDY), "R9 ld_ready", CTX_W'(ld_ready), CTX_W'(r_st == R_RDY));
        if (r_st == 1) begin
            chk(ctx_wr_data == r_ctx, "R7 R10 ctx_wr_data", ctx_wr_data, r_ctx);
            chk(ld_src == r_src, "R7 ld_src", CTX_W'(ld_src), CTX_W'(r_src));
            chk(ld_thread == r_tid, "R7 ld_thread", CTX_W'(ld_thread), CTX_W'(r_tid));
            chk(ld_evict == r_ev, "R7 ld_evict", CTX_W'(ld_evict), CTX_W'(r_ev));
            chk(ld_native == (r_nat == my_core), "R7 ld_native", CTX_W'(ld_native),
                CTX_W'(r_nat == my_core));
        end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        ncyc++;
        compare();
    endtask

    // Send one context out; mode 0 ready always, 1 ready toggling, 2 long stall.
    task automatic do_unload(input logic [CORE_W-1:0] dst, input logic [CORE_W-1:0] nat,
                             input logic [TID_W-1:0] tid, input bit ev, input int mode);
        ul_dst = dst; ul_native = nat; ul_thread = tid; ul_evict = ev;
        ctx_rd_data = rnd_ctx();
        ul_start = 1'b1;
        tx_ready = (mode == 0);
        tick();
        ul_start = 1'b0;
        // R6: new data and a second start while busy must not alter the packet
        ctx_rd_data = rnd_ctx();
        ul_dst = ~dst;
        ul_start = 1'b1;
        tick();
        ul_start = 1'b0;
        for (int i = 0; i < 80 && (m_busy || m_done); i++) begin
            if (mode == 1)      tx_ready = (i % 3 != 0);
            else if (mode == 2) tx_ready = (i >= 6);
            else                tx_ready = 1'b1;
            tick();
        end
        tx_ready = 1'b0;
        tick();
    endtask

    // Bring one context in; gap=1 inserts idle cycles between flits.
    task automatic do_load(input logic [CORE_W-1:0] src, input logic [CORE_W-1:0] nat,
                           input logic [TID_W-1:0] tid, input bit ev, input bit gap);
        logic [FLIT_W-1:0] fl[$];
        r_ctx = rnd_ctx();
        r_src = src; r_nat = nat; r_tid = tid; r_ev = ev;
        fl.push_back(mk_hdr(my_core, src, nat, tid, ev));
        for (int k = 0; k < NFL; k++) fl.push_back(r_ctx[k*FLIT_W +: FLIT_W]);
        for (int j = 0; j < NFL + 1; j++) begin
            bit acc;
            acc = 0;
            for (int t = 0; t < 10 && !acc; t++) begin
                rx_flit  = fl[j];
                rx_valid = gap ? (t % 2 == 1) : 1'b1;
                acc = rx_valid && (r_st == 0);
                tick();
            end
        end
        // R8: offered flits during write/insert/ready must not be taken
        for (int t = 0; t < 10 && r_st != 0; t++) begin
            rx_valid = 1'b1;
            rx_flit  = {FLIT_W{1'b1}};
            tick();
        end
        rx_valid = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(tx_valid == 1'b0, "R1 tx_valid", CTX_W'(tx_valid), '0);
        chk(tx_last == 1'b0, "R1 tx_last", CTX_W'(tx_last), '0);
        chk(ul_busy == 1'b0, "R1 ul_busy", CTX_W'(ul_busy), '0);
        chk(ul_done == 1'b0, "R1 ul_done", CTX_W'(ul_done), '0);
        chk(ctx_wr_en == 1'b0, "R1 ctx_wr_en", CTX_W'(ctx_wr_en), '0);
        chk(ld_ready == 1'b0, "R1 ld_ready", CTX_W'(ld_ready), '0);
        chk(rx_ready == 1'b1, "R1 rx_ready", CTX_W'(rx_ready), CTX_W'(1));
        rst_n = 1'b1;
        tick();
        do_unload(8'h11, 8'h05, 4'h3, 1'b0, 0);   // R2 R3 R5
        do_unload(8'hC4, 8'h7E, 4'hA, 1'b1, 1);   // R4 R6 toggling ready
        do_unload(8'h00, 8'hFF, 4'hF, 1'b1, 2);   // R4 long stall
        do_load(8'h09, 8'h2A, 4'h6, 1'b0, 1'b0);  // R7 native slot
        do_load(8'h33, 8'h12, 4'h1, 1'b1, 1'b1);  // R10 gaps, guest slot
        do_load(8'hFE, 8'h2A, 4'h0, 1'b1, 1'b0);  // R9 back to back
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=100000 cycles expected=fewer");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule